// File: doc/BRIEF.md
# Per-Set Recency List with Victim Selection

This block keeps the replacement order for a set-associative cache. Each set has its own list of way numbers held in slots. Slot 0 is the least recently used (LRU) end and slot `NUM_WAYS-1` is the most recently used (MRU) end. When a way is accessed, it is taken out of its slot and placed at the MRU end. Every entry that sat above its old slot moves down by one place. The entries below that slot stay where they are.

The victim for a set is the way in slot 0. A cache controller reads the victim of the set it is working on, fills that way, and reports the fill as an ordinary access. That access moves the filled way to the MRU end. With `NUM_SETS = 1` the block keeps a single list for a fully associative cache. The block holds no tags and no data. It accepts at most one update per clock. The full order of every set is brought out for observation.

Top module: `lru_order_list`

## Requirements
- R1: After reset, slot k of every set holds way k, so way 0 is the victim of every set.
- R2: An access (`acc_valid_i` high at a clock edge) to way W of set S places W in the MRU slot (`NUM_WAYS-1`) of S after that edge.
- R3: On that access, suppose W was in slot p. Then each slot k with p <= k < `NUM_WAYS-1` takes the way that was in slot k+1, and each slot below p keeps its way.
- R4: An access to the way that is already in the MRU slot leaves the list of that set unchanged.
- R5: `victim_o` equals the way in slot 0 of set `qry_set_i`, with no clock delay.
- R6: An access changes only the list of the addressed set. All other sets keep their order.
- R7: A query made in the same cycle as an update to the same set returns the order from before the update. The new order becomes visible after the edge.
- R8: When `acc_valid_i` is low, no list changes, whatever values are on `acc_set_i` and `acc_way_i`.
- R9: Each set's list always holds every way number from 0 to `NUM_WAYS-1` exactly once.
- R10: A fill into the reported victim way moves that way to the MRU slot. The way that was in slot 1 becomes the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe; one update per cycle |
| acc_set_i | input | SET_W | Set index of the access |
| acc_way_i | input | WAY_W | Way that was accessed or filled |
| qry_set_i | input | SET_W | Set whose victim is requested |
| victim_o | output | WAY_W | Way in the LRU slot of the queried set |
| order_o | output | NUM_SETS*NUM_WAYS*WAY_W | All lists; set s, slot k at bit offset (s*NUM_WAYS+k)*WAY_W |

## Verification
A victim query and an order update can land on the same set in the same cycle. The bench provokes this by pointing `qry_set_i` at the set it is updating, while `acc_valid_i` is already driven and before the edge arrives. It samples `victim_o` there and expects the slot-0 way that the bench's own model held before the access. After the edge it expects the rotated result. Fills are handled the same way: the bench reads the victim, writes it back as the accessed way, and judges the next victim against the way the model held in slot 1.

// File: rtl/lru_pkg.sv
package lru_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_reorder.sv
module lru_reorder #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic [NUM_WAYS*WAY_W-1:0] list_i,
  input  logic [WAY_W-1:0]          way_i,
  output logic [NUM_WAYS*WAY_W-1:0] list_o
);
  logic [NUM_WAYS-1:0] match;
  logic [NUM_WAYS-1:0] seen;   // old position of way_i is at or below slot k

  for (genvar k = 0; k < NUM_WAYS; k++) begin : g_slot
    assign match[k] = (list_i[k*WAY_W +: WAY_W] == way_i);
    if (k == 0) begin : g_first
      assign seen[k] = match[k];
    end else begin : g_rest
      assign seen[k] = seen[k-1] | match[k];
    end
    if (k == NUM_WAYS - 1) begin : g_mru
      assign list_o[k*WAY_W +: WAY_W] = way_i;
    end else begin : g_shift
      assign list_o[k*WAY_W +: WAY_W] = seen[k] ? list_i[(k+1)*WAY_W +: WAY_W]
                                                : list_i[k*WAY_W +: WAY_W];
    end
  end
endmodule

// File: rtl/lru_set_list.sv
module lru_set_list #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_i,
  input  logic [NUM_WAYS*WAY_W-1:0] next_i,
  output logic [NUM_WAYS*WAY_W-1:0] list_o
);
  for (genvar k = 0; k < NUM_WAYS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    list_o[k*WAY_W +: WAY_W] <= WAY_W'(k);
      else if (upd_i) list_o[k*WAY_W +: WAY_W] <= next_i[k*WAY_W +: WAY_W];
    end
  end
endmodule

// File: rtl/lru_order_list.sv
module lru_order_list #(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W   = lru_pkg::idx_w(NUM_SETS),
  localparam int unsigned WAY_W   = lru_pkg::idx_w(NUM_WAYS),
  localparam int unsigned LIST_W  = NUM_WAYS * WAY_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_valid_i,
  input  logic [SET_W-1:0]           acc_set_i,
  input  logic [WAY_W-1:0]           acc_way_i,
  input  logic [SET_W-1:0]           qry_set_i,
  output logic [WAY_W-1:0]           victim_o,
  output logic [NUM_SETS*LIST_W-1:0] order_o
);
  logic [LIST_W-1:0] lists [NUM_SETS];
  logic [LIST_W-1:0] cur_list;
  logic [LIST_W-1:0] nxt_list;

  // single shared reorder path; only one set updates per cycle
  assign cur_list = lists[acc_set_i];

  lru_reorder #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_reorder (
    .list_i (cur_list),
    .way_i  (acc_way_i),
    .list_o (nxt_list)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic upd;
    assign upd = acc_valid_i && (acc_set_i == SET_W'(s));

    lru_set_list #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_list (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd),
      .next_i (nxt_list),
      .list_o (lists[s])
    );

    assign order_o[s*LIST_W +: LIST_W] = lists[s];
  end

  assign victim_o = lists[qry_set_i][WAY_W-1:0];
endmodule

// File: rtl/lru_order_chk.sv
module lru_order_chk #(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W   = lru_pkg::idx_w(NUM_SETS),
  localparam int unsigned WAY_W   = lru_pkg::idx_w(NUM_WAYS),
  localparam int unsigned LIST_W  = NUM_WAYS * WAY_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       acc_valid_i,
  input logic [SET_W-1:0]           acc_set_i,
  input logic [WAY_W-1:0]           acc_way_i,
  input logic [SET_W-1:0]           qry_set_i,
  input logic [WAY_W-1:0]           victim_o,
  input logic [NUM_SETS*LIST_W-1:0] order_o
);
  function automatic logic [WAY_W-1:0] slot_of(logic [NUM_SETS*LIST_W-1:0] ord,
                                                logic [SET_W-1:0] s, int unsigned k);
    return ord[(int'(s)*NUM_WAYS + k)*WAY_W +: WAY_W];
  endfunction

  logic perm_ok;
  always_comb begin
    perm_ok = 1'b1;
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < NUM_WAYS; k++)
          if (order_o[(s*NUM_WAYS+k)*WAY_W +: WAY_W] == WAY_W'(w)) cnt++;
        if (cnt != 1) perm_ok = 1'b0;
      end
    end
  end

  // R2
  mru_placed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> slot_of(order_o, $past(acc_set_i), NUM_WAYS-1) == $past(acc_way_i));

  // R4
  mru_hit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && slot_of(order_o, acc_set_i, NUM_WAYS-1) == acc_way_i) |=> $stable(order_o));

  // R5
  victim_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_o == slot_of(order_o, qry_set_i, 0));

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(order_o));

  // R9
  perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) perm_ok);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_other
    // R6
    other_set_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_set_i != SET_W'(s)) |=> $stable(order_o[s*LIST_W +: LIST_W]));
  end
endmodule

bind lru_order_list lru_order_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_set_i   (acc_set_i),
  .acc_way_i   (acc_way_i),
  .qry_set_i   (qry_set_i),
  .victim_o    (victim_o),
  .order_o     (order_o)
);

// File: tb/tb_lru_order_list.sv
`timescale 1ns/1ps
module tb_lru_order_list;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam int WW = 2;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [WW-1:0] acc_way = '0;
  logic [SW-1:0] qry_set = '0;
  logic [WW-1:0] victim;
  logic [NS*NW*WW-1:0] order;

  int checks = 0;
  int failures = 0;
  int model [NS][NW];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  lru_order_list #(.NUM_SETS(NS), .NUM_WAYS(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_set_i(acc_set),
    .acc_way_i(acc_way), .qry_set_i(qry_set), .victim_o(victim), .order_o(order)
  );

  function automatic int slot(int s, int k);
    return int'(order[(s*NW+k)*WW +: WW]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_touch(input int s, input int w);
    int p;
    p = NW - 1;
    for (int k = 0; k < NW; k++) if (model[s][k] == w) p = k;
    for (int k = p; k < NW - 1; k++) model[s][k] = model[s][k+1];
    model[s][NW-1] = w;
  endtask

  task automatic cmp_all(input int touched, input string tag_set);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NW; k++) begin
        int exp;
        int act;
        exp = model[s][k];
        act = slot(s, k);
        if (s != touched) chk(act == exp, "R6 other set", act, exp);
        else if (k == NW - 1) chk(act == exp, {tag_set, " R2 mru slot"}, act, exp);
        else chk(act == exp, {tag_set, " R3 shifted slot"}, act, exp);
      end
  endtask

  task automatic access(input int s, input int w);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_set = SW'(s);
    acc_way = WW'(w);
    qry_set = SW'(s);
    #0.5;
    // R7: still the pre-update victim
    chk(int'(victim) == model[s][0], "R7 same-cycle query", int'(victim), model[s][0]);
    @(posedge clk);
    #0.5;
    acc_valid = 1'b0;
    model_touch(s, w);
  endtask

  bit done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int k = 0; k < NW; k++) model[s][k] = k;
    #12;
    // R1: reset order
    for (int s = 0; s < NS; s++) for (int k = 0; k < NW; k++)
      chk(slot(s, k) == k, "R1 reset order", slot(s, k), k);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      qry_set = SW'(s);
      #0.2;
      chk(int'(victim) == 0, "R1 reset victim", int'(victim), 0);
    end

    // R2 R3 R4 R6: pseudo-random sweep
    for (int n = 0; n < 400; n++) begin
      int s;
      int w;
      bit is_mru;
      seed = seed * 32'd1103515245 + 32'd12345;
      s = int'(seed[17:16]);
      w = int'(seed[21:20]);
      is_mru = (model[s][NW-1] == w);
      access(s, w);
      cmp_all(s, is_mru ? "R4" : "R2R3");
    end

    // R3: exhaustive, every starting position in one set
    for (int p = 0; p < NW; p++) begin
      access(1, model[1][p]);
      cmp_all(1, "R3 pos sweep");
    end

    // R4: touch the MRU repeatedly
    for (int r = 0; r < 3; r++) begin
      access(2, model[2][NW-1]);
      cmp_all(2, "R4 mru hit");
    end

    // R8: strobe low with varying set and way
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      acc_valid = 1'b0;
      acc_set = SW'(s);
      acc_way = WW'(w);
      @(posedge clk);
      #0.5;
      for (int ss = 0; ss < NS; ss++) for (int k = 0; k < NW; k++)
        chk(slot(ss, k) == model[ss][k], "R8 idle no change", slot(ss, k), model[ss][k]);
    end

    // R5: victim for every query set
    for (int s = 0; s < NS; s++) begin
      qry_set = SW'(s);
      #0.2;
      chk(int'(victim) == model[s][0], "R5 victim slot0", int'(victim), model[s][0]);
    end

    // R10: fill the victim, next victim is old slot 1
    for (int s = 0; s < NS; s++) for (int r = 0; r < NW; r++) begin
      int v;
      int nxt;
      qry_set = SW'(s);
      #0.2;
      v = int'(victim);
      nxt = model[s][1];
      access(s, v);
      #0.2;
      chk(int'(victim) == nxt, "R10 next victim", int'(victim), nxt);
      chk(slot(s, NW-1) == v, "R10 fill at mru", slot(s, NW-1), v);
    end

    // R9: each list a permutation
    for (int s = 0; s < NS; s++) begin
      int mask;
      mask = 0;
      for (int k = 0; k < NW; k++) mask |= (1 << slot(s, k));
      chk(mask == (1 << NW) - 1, "R9 permutation", mask, (1 << NW) - 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule